// File: doc/BRIEF.md
# Pointer Bank Address Generator

This block keeps a bank of address pointers and turns each accepted access request into one memory address. The request names a pointer, an update mode and, where the mode needs them, a signed immediate offset or a second pointer used as an index. The block emits the address and rewrites the chosen pointer in the same clock edge. Ordinary walking modes emit the pointer before changing it. Stack push emits the pointer after incrementing it, and pop mirrors push. Indexed access adds two pointers and changes neither.

All candidate addresses come from a set of adders that run in parallel. A final selector picks one of them and feeds the output register. Pre-increment therefore adds no delay beyond what post-modification already has. A separate write port loads any pointer directly.

Requests enter on a valid/ready handshake, and addresses leave on one. An address is held until the consumer takes it. While an address waits, new requests are refused and no pointer moves. `req_ready` is high whenever the output register is empty or is being drained in the same cycle.

Top module: `agu_ptr_unit`

## Requirements
- R1: After reset every pointer is 0, `out_valid` is 0 and `req_ready` is 1.
- R2: Mode code 0 (walk up) emits the selected pointer, then stores pointer+1.
- R3: Mode code 1 (walk down) emits the selected pointer, then stores pointer-1.
- R4: Mode code 2 (offset step) emits the selected pointer, then stores pointer+K. K is `req_ofs` read as 8-bit two's complement and sign-extended.
- R5: Mode code 3 (push) stores pointer+1 and emits that new value.
- R6: Mode code 4 (pop) emits the selected pointer, then stores pointer-1.
- R7: Mode code 5 (indexed) emits the selected pointer plus the pointer named by `req_idx`. No pointer changes.
- R8: Mode codes 6 and 7 emit the selected pointer unchanged and update nothing.
- R9: All pointer and address arithmetic wraps modulo 2^16, with no flag.
- R10: When `wr_en` is high, `wr_data` is loaded into pointer `wr_sel`. The load wins over a mode update of the same pointer in the same cycle. A request in that cycle reads the values the pointers held before the edge.
- R11: A request is accepted when `req_valid` and `req_ready` are both high. Its address appears with `out_valid` in the next cycle, and the pointer update lands on that same edge. With no new acceptance, a taken address clears `out_valid`.
- R12: `req_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_addr` holds steady and no request changes any pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_sel | input | 3 | Pointer used by the access |
| req_mode | input | 3 | Update mode code |
| req_ofs | input | 8 | Signed immediate step for mode 2 |
| req_idx | input | 3 | Pointer used as index in mode 5 |
| wr_en | input | 1 | Direct pointer load |
| wr_sel | input | 3 | Pointer to load |
| wr_data | input | 16 | Load value |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | 16 | Generated address |

## Verification
The hardest case to reach from the ports is a cycle where three things meet. The output is stalled, a request is pending, and the write port loads the very pointer that request names. That cycle must show both the refusal and the write priority together. Pointers can only be seen through later accesses, so the stimulus also needs follow-up requests on the same pointer. Directed sequences build these collisions and wrap-arounds at 0 and 0xFFFF on purpose. A seeded random phase then mixes a sparse pointer selection, frequent write-port traffic and a stalling consumer. Every outcome is compared against a cycle model of the bank.

// File: rtl/agu_ptr_pkg.sv
package agu_ptr_pkg;

  typedef enum logic [2:0] {
    MODE_INC   = 3'd0,
    MODE_DEC   = 3'd1,
    MODE_ADD   = 3'd2,
    MODE_PUSH  = 3'd3,
    MODE_POP   = 3'd4,
    MODE_INDEX = 3'd5,
    MODE_RSV6  = 3'd6,
    MODE_RSV7  = 3'd7
  } acc_mode_e;

  typedef enum logic [1:0] {
    EMIT_OLD = 2'd0,
    EMIT_INC = 2'd1,
    EMIT_IDX = 2'd2
  } emit_src_e;

  typedef enum logic [1:0] {
    NEXT_INC  = 2'd0,
    NEXT_DEC  = 2'd1,
    NEXT_ADD  = 2'd2,
    NEXT_HOLD = 2'd3
  } next_src_e;

  typedef struct packed {
    emit_src_e emit;
    next_src_e nxt;
    logic      upd;
  } acc_ctrl_t;

endpackage

// File: rtl/agu_mode_decode.sv
module agu_mode_decode
  import agu_ptr_pkg::*;
(
  input  logic [2:0] mode,
  output acc_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{emit: EMIT_OLD, nxt: NEXT_HOLD, upd: 1'b0};
    case (acc_mode_e'(mode))
      MODE_INC:   ctrl = '{emit: EMIT_OLD, nxt: NEXT_INC, upd: 1'b1};
      MODE_DEC:   ctrl = '{emit: EMIT_OLD, nxt: NEXT_DEC, upd: 1'b1};
      MODE_ADD:   ctrl = '{emit: EMIT_OLD, nxt: NEXT_ADD, upd: 1'b1};
      MODE_PUSH:  ctrl = '{emit: EMIT_INC, nxt: NEXT_INC, upd: 1'b1};
      MODE_POP:   ctrl = '{emit: EMIT_OLD, nxt: NEXT_DEC, upd: 1'b1};
      MODE_INDEX: ctrl = '{emit: EMIT_IDX, nxt: NEXT_HOLD, upd: 1'b0};
      default:    ctrl = '{emit: EMIT_OLD, nxt: NEXT_HOLD, upd: 1'b0};
    endcase
  end

endmodule

// File: rtl/agu_cand.sv
module agu_cand #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic [AW-1:0] cur_p,
  input  logic [AW-1:0] idx_p,
  input  logic [OW-1:0] ofs,
  output logic [AW-1:0] p_inc,
  output logic [AW-1:0] p_dec,
  output logic [AW-1:0] p_add,
  output logic [AW-1:0] p_idx
);

  logic [AW-1:0] ofs_ext;

  generate
    if (OW < AW) begin : g_sext
      assign ofs_ext = {{(AW-OW){ofs[OW-1]}}, ofs};
    end else begin : g_trunc
      assign ofs_ext = ofs[AW-1:0];
    end
  endgenerate

  // all candidates side by side; truncation gives modulo 2^AW wrap
  assign p_inc = cur_p + AW'(1);
  assign p_dec = cur_p - AW'(1);
  assign p_add = cur_p + ofs_ext;
  assign p_idx = cur_p + idx_p;

endmodule

// File: rtl/agu_regbank.sv
module agu_regbank #(
  parameter int NREG = 8,
  parameter int AW   = 16,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_sel,
  input  logic [AW-1:0] upd_val,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] ptr_q [NREG]
);

  for (genvar g = 0; g < NREG; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_q[g] <= '0;
      else if (wr_en && wr_sel == SW'(g))
        ptr_q[g] <= wr_data;
      else if (upd_en && upd_sel == SW'(g))
        ptr_q[g] <= upd_val;
    end

    // R12: a pointer touched by neither port keeps its value
    a_r12_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SW'(g)) && !(upd_en && upd_sel == SW'(g))
      |=> $stable(ptr_q[g]));
  end

  // R10: the write port beats a same-cycle update
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr_q[$past(wr_sel)] == $past(wr_data));

endmodule

// File: rtl/agu_emit.sv
module agu_emit
  import agu_ptr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  emit_src_e     src,
  input  logic [AW-1:0] cur_p,
  input  logic [AW-1:0] p_inc,
  input  logic [AW-1:0] p_idx,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr
);

  logic [AW-1:0] addr_d;

  // final selector: only a mux sits between candidates and the register
  always_comb begin
    case (src)
      EMIT_INC: addr_d = p_inc;
      EMIT_IDX: addr_d = p_idx;
      default:  addr_d = cur_p;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_addr  <= addr_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R12: stalled address is held
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));

  // R11: accepted request shows up next cycle
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R11: a taken address with nothing behind it clears the flag
  a_r11_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !accept |=> !out_valid);

endmodule

// File: rtl/agu_ptr_unit.sv
module agu_ptr_unit
  import agu_ptr_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 16,
  parameter int OW   = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_sel,
  input  logic [2:0]    req_mode,
  input  logic [OW-1:0] req_ofs,
  input  logic [SW-1:0] req_idx,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);

  logic [AW-1:0] ptr_q [NREG];
  logic [AW-1:0] cur_p, idx_p;
  logic [AW-1:0] p_inc, p_dec, p_add, p_idx;
  logic [AW-1:0] upd_val;
  logic          accept, upd_en;
  acc_ctrl_t     ctrl;

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;
  assign cur_p     = ptr_q[req_sel];
  assign idx_p     = ptr_q[req_idx];
  assign upd_en    = accept && ctrl.upd;

  agu_mode_decode u_dec (
    .mode (req_mode),
    .ctrl (ctrl)
  );

  agu_cand #(.AW(AW), .OW(OW)) u_cand (
    .cur_p (cur_p),
    .idx_p (idx_p),
    .ofs   (req_ofs),
    .p_inc (p_inc),
    .p_dec (p_dec),
    .p_add (p_add),
    .p_idx (p_idx)
  );

  always_comb begin
    case (ctrl.nxt)
      NEXT_INC: upd_val = p_inc;
      NEXT_DEC: upd_val = p_dec;
      NEXT_ADD: upd_val = p_add;
      default:  upd_val = cur_p;
    endcase
  end

  agu_regbank #(.NREG(NREG), .AW(AW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .upd_sel (req_sel),
    .upd_val (upd_val),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ptr_q   (ptr_q)
  );

  agu_emit #(.AW(AW)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .src       (ctrl.emit),
    .cur_p     (cur_p),
    .p_inc     (p_inc),
    .p_idx     (p_idx),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_addr  (out_addr)
  );

  // R5: push emits exactly the value the pointer now holds
  a_r5_push_match: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_mode == 3'd3 && !(wr_en && wr_sel == req_sel)
    |=> out_addr == ptr_q[$past(req_sel)]);

  // R2: walk up emits the old value and leaves old+1 behind
  a_r2_walk_up: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_mode == 3'd0 && !(wr_en && wr_sel == req_sel)
    |=> out_addr == $past(cur_p) && ptr_q[$past(req_sel)] == $past(cur_p) + AW'(1));

  // R7 / R8: indexed and reserved codes leave the pointer alone
  a_r8_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_mode >= 3'd5 && !(wr_en && wr_sel == req_sel)
    |=> ptr_q[$past(req_sel)] == $past(cur_p));

  // R1: nothing comes out right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/sim_agu_ptr_unit.sv
`timescale 1ns/1ps
module sim_agu_ptr_unit;
  localparam int NREG = 8, AW = 16, OW = 8, SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, out_ready = 1, wr_en = 0;
  logic [SW-1:0] req_sel = 0, req_idx = 0, wr_sel = 0;
  logic [2:0] req_mode = 0;
  logic [OW-1:0] req_ofs = 0;
  logic [AW-1:0] wr_data = 0;
  logic req_ready, out_valid;
  logic [AW-1:0] out_addr;

  int n_chk = 0, n_err = 0;
  logic [AW-1:0] mp [NREG];
  logic eov = 0;
  logic [AW-1:0] eaddr = 0;
  logic [2:0] lmode = 0;

  always #2 clk = ~clk;

  agu_ptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_mode(req_mode), .req_ofs(req_ofs), .req_idx(req_idx),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
  );

  function automatic string mtag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // cycle model of the bank and output register (applied at each edge)
  task automatic model_step();
    logic acc, upd;
    logic [AW-1:0] p, q, a, np;
    acc = req_valid && (!eov || out_ready);
    if (acc) begin
      p = mp[req_sel]; q = mp[req_idx]; upd = 1'b1; np = p; a = p;
      case (req_mode)
        3'd0: np = p + 16'd1;
        3'd1: np = p - 16'd1;
        3'd2: np = p + {{8{req_ofs[7]}}, req_ofs};
        3'd3: begin np = p + 16'd1; a = np; end
        3'd4: np = p - 16'd1;
        3'd5: begin a = p + q; upd = 1'b0; end
        default: upd = 1'b0;
      endcase
      if (upd) mp[req_sel] = np;
      eaddr = a; eov = 1'b1; lmode = req_mode;
    end else if (out_ready) begin
      eov = 1'b0;
    end
    if (wr_en) mp[wr_sel] = wr_data;
  endtask

  task automatic cyc(input string tag);
    string t;
    @(posedge clk);
    model_step();
    @(negedge clk);
    t = (tag == "") ? mtag(lmode) : tag;
    chk(t, "out_valid", {31'd0, out_valid}, {31'd0, eov});
    if (eov) chk(t, "out_addr", {16'd0, out_addr}, {16'd0, eaddr});
    chk("R12", "req_ready", {31'd0, req_ready}, {31'd0, (!eov || out_ready)});
  endtask

  task automatic req(input logic [2:0] s, input logic [2:0] m, input logic [7:0] k,
                     input logic [2:0] ix, input string tag);
    req_valid = 1; req_sel = s; req_mode = m; req_ofs = k; req_idx = ix;
    cyc(tag);
    req_valid = 0; wr_en = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    cyc("R10");
    wr_en = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NREG; i++) mp[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1;
    req(3'd3, 3'd0, 8'd0, 3'd0, "R1");           // pointer 3 starts at 0
    wr(3'd0, 16'h1000);
    req(3'd0, 3'd0, 8'd0, 3'd0, "R2");
    req(3'd0, 3'd1, 8'd0, 3'd0, "R3");
    req(3'd0, 3'd2, 8'hFD, 3'd0, "R4");          // -3
    req(3'd0, 3'd2, 8'h05, 3'd0, "R4");
    req(3'd0, 3'd0, 8'd0, 3'd0, "R4");
    wr(3'd1, 16'h2000);
    req(3'd1, 3'd3, 8'd0, 3'd0, "R5");
    req(3'd1, 3'd3, 8'd0, 3'd0, "R5");
    req(3'd1, 3'd4, 8'd0, 3'd0, "R6");
    req(3'd1, 3'd4, 8'd0, 3'd0, "R6");
    req(3'd0, 3'd5, 8'd0, 3'd1, "R7");
    req(3'd0, 3'd5, 8'd0, 3'd1, "R7");
    req(3'd1, 3'd6, 8'd0, 3'd0, "R8");
    req(3'd1, 3'd7, 8'd0, 3'd0, "R8");
    req(3'd1, 3'd0, 8'd0, 3'd0, "R8");
    wr(3'd2, 16'hFFFF);
    req(3'd2, 3'd0, 8'd0, 3'd0, "R9");
    req(3'd2, 3'd0, 8'd0, 3'd0, "R9");
    req(3'd2, 3'd4, 8'd0, 3'd0, "R9");
    req(3'd2, 3'd3, 8'd0, 3'd0, "R9");
    req(3'd2, 3'd2, 8'h80, 3'd0, "R9");
    // R10: load and push hit pointer 4 in the same cycle
    wr_en = 1; wr_sel = 3'd4; wr_data = 16'h4000;
    req(3'd4, 3'd3, 8'd0, 3'd0, "R10");
    req(3'd4, 3'd0, 8'd0, 3'd0, "R10");
    cyc("R11");                                  // idle: valid must drop
    // R12: stall the consumer
    out_ready = 0;
    req(3'd5, 3'd0, 8'd0, 3'd0, "R12");
    req_valid = 1; req_sel = 3'd5; req_mode = 3'd0;
    wr_en = 1; wr_sel = 3'd5; wr_data = 16'h5555;
    cyc("R12");
    wr_en = 0;
    cyc("R12");
    out_ready = 1;
    cyc("R12");
    req_valid = 0;
    req(3'd5, 3'd0, 8'd0, 3'd0, "R12");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      req_valid = ($urandom % 4) != 0;
      req_sel   = 3'($urandom % 3);
      req_idx   = 3'($urandom);
      req_mode  = 3'($urandom);
      req_ofs   = 8'($urandom);
      out_ready = ($urandom % 4) != 0;
      wr_en     = ($urandom % 5) == 0;
      wr_sel    = 3'($urandom % 3);
      wr_data   = (($urandom % 4) == 0) ? 16'hFFFE : 16'($urandom);
      cyc("");
    end
    req_valid = 0; wr_en = 0; out_ready = 1;
    cyc("R11");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule